// File: doc/BRIEF.md
# Folding One-Hot to Binary Encoder

This block is a purely combinational encoder that turns a 2^n-bit one-hot word into the n-bit binary position of its set bit. It suits places where a grant, select or match line is already known to be one-hot and only its index is needed downstream, for example to steer a multiplexer or to address a table. It is a one-hot encoder, not a priority encoder. If the input is all zero, the output is all zero. If more than one bit is set, the output is not defined, and nothing downstream may rely on it.

The structure is recursive. At each level the input word is split into an upper half and a lower half. The upper half is OR-reduced through a balanced tree, and that result is the most significant output bit. The two halves are then ORed bit by bit into a word half as wide, and that word feeds one encoder of the next smaller size, which supplies the remaining output bits. At the single-level base, the output bit is simply the upper input bit and no gate is used. Total OR gate count grows linearly in the input width. Logic depth grows linearly in n.

Top module: `ohf_encoder`

## Requirements
- R1: When exactly one bit j of `in_vec` is set, `idx_out` equals j as an unsigned binary number, so that `in_vec[idx_out]` is 1.
- R2: When `in_vec` is all zero, `idx_out` is all zero.
- R3: With LEVELS = 1, `idx_out[0]` equals `in_vec[1]`: input 2'b10 gives 1 and input 2'b01 gives 0.
- R4: For a one-hot input, the most significant output bit `idx_out[LEVELS-1]` is 1 exactly when the set bit lies in the upper half of `in_vec` (positions 2^(LEVELS-1) and above).
- R5: For a one-hot input with the set bit at position j and LEVELS > 1, the lower output bits `idx_out[LEVELS-2:0]` equal j modulo 2^(LEVELS-1), the position of the set bit within its half.
- R6: With LEVELS = 3, input 8'b0010_0000 gives output 3'b101.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_vec | input | 2**LEVELS | One-hot (or all-zero) input word |
| idx_out | output | LEVELS | Binary position of the set input bit; zero for a zero input |

## Verification
The bench builds six copies of the encoder, with LEVELS set to 1, 2, 3, 4, 5 and 6. It drives all of them from one shared 64-bit stimulus, and each copy takes the low bits it needs. Walking a single set bit across all 64 positions therefore reaches every one-hot pattern of every size. The same walk also produces the case where a smaller copy sees an all-zero word because the set bit falls beyond its width. The LEVELS = 1 copy exercises the gate-free base case on its own. The LEVELS = 3 copy reproduces the worked example of R6. Random single-bit patterns from a fixed seed repeat these checks in a scrambled order, and multi-hot inputs are never checked.

// File: rtl/ohf_pkg.sv
package ohf_pkg;

    // Largest recursion depth the encoder is meant for.
    localparam int unsigned OHF_MAX_LEVELS = 16;

    // Width of a one-hot word that an encoder of the given depth accepts.
    function automatic int unsigned ohf_span(input int unsigned levels);
        return 32'd1 << levels;
    endfunction

endpackage

// File: rtl/ohf_or_tree.sv
// Balanced OR reduction: split in two, reduce each side, combine.
module ohf_or_tree #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] vec,
    output logic             any
);
    localparam int unsigned LO_W = WIDTH / 2;
    localparam int unsigned HI_W = WIDTH - LO_W;

    generate
        if (WIDTH == 1) begin : g_leaf
            assign any = vec[0];
        end else begin : g_split
            logic any_lo;
            logic any_hi;

            ohf_or_tree #(.WIDTH(LO_W)) u_lo (
                .vec (vec[LO_W-1:0]),
                .any (any_lo)
            );

            ohf_or_tree #(.WIDTH(HI_W)) u_hi (
                .vec (vec[WIDTH-1:LO_W]),
                .any (any_hi)
            );

            assign any = any_lo | any_hi;
        end
    endgenerate
endmodule

// File: rtl/ohf_fold_stage.sv
// One level of the folding encoder. It emits the top index bit from the
// upper half, then recurses on the bitwise OR of both halves.
module ohf_fold_stage
    import ohf_pkg::*;
#(
    parameter int unsigned LEVELS = 4
) (
    input  logic [ohf_span(LEVELS)-1:0] vec,
    output logic [LEVELS-1:0]           idx
);
    localparam int unsigned SPAN = ohf_span(LEVELS);
    localparam int unsigned HALF = SPAN / 2;

    generate
        if (LEVELS == 1) begin : g_base
            // Position 1 is set exactly when the index is 1; zero costs no gate.
            assign idx[0] = vec[1];
        end else begin : g_fold
            logic [HALF-1:0] upper;
            logic [HALF-1:0] lower;
            logic [HALF-1:0] folded;

            assign upper  = vec[SPAN-1:HALF];
            assign lower  = vec[HALF-1:0];
            assign folded = upper | lower;

            ohf_or_tree #(.WIDTH(HALF)) u_upper_any (
                .vec (upper),
                .any (idx[LEVELS-1])
            );

            ohf_fold_stage #(.LEVELS(LEVELS-1)) u_next (
                .vec (folded),
                .idx (idx[LEVELS-2:0])
            );
        end
    endgenerate
endmodule

// File: rtl/ohf_encoder.sv
// Top of the folding one-hot to binary encoder.
module ohf_encoder
    import ohf_pkg::*;
#(
    parameter int unsigned LEVELS = 4
) (
    input  logic [ohf_span(LEVELS)-1:0] in_vec,
    output logic [LEVELS-1:0]           idx_out
);
    initial begin
        if (LEVELS < 1 || LEVELS > OHF_MAX_LEVELS) begin
            $display("ohf_encoder: LEVELS %0d outside 1..%0d", LEVELS, OHF_MAX_LEVELS);
        end
    end

    ohf_fold_stage #(.LEVELS(LEVELS)) u_stage (
        .vec (in_vec),
        .idx (idx_out)
    );
endmodule

// File: rtl/ohf_encoder_chk.sv
// Port-level checks for the folding encoder, attached with bind below.
module ohf_encoder_chk
    import ohf_pkg::*;
#(
    parameter int unsigned LEVELS = 4
) (
    input logic [ohf_span(LEVELS)-1:0] in_vec,
    input logic [LEVELS-1:0]           idx_out
);
    localparam int unsigned SPAN = ohf_span(LEVELS);
    localparam int unsigned HALF = SPAN / 2;

    always_comb begin
        if ($onehot(in_vec)) begin
            a_r1_index_hits_set_bit: assert (in_vec[idx_out] == 1'b1);
            a_r4_msb_tracks_upper_half: assert (idx_out[LEVELS-1] == (|in_vec[SPAN-1:HALF]));
        end
        if (in_vec == '0) begin
            a_r2_zero_in_zero_out: assert (idx_out == '0);
        end
    end

    generate
        if (LEVELS == 1) begin : g_base_chk
            always_comb begin
                if (!$isunknown(in_vec)) begin
                    a_r3_base_follows_upper_bit: assert (idx_out[0] == in_vec[1]);
                end
            end
        end else begin : g_fold_chk
            logic [SPAN-1:0] shifted;
            assign shifted = in_vec >> idx_out[LEVELS-2:0];
            always_comb begin
                if ($onehot(in_vec)) begin
                    a_r5_low_bits_within_half: assert (shifted[0] | shifted[HALF]);
                end
            end
        end
    endgenerate
endmodule

bind ohf_encoder ohf_encoder_chk #(.LEVELS(LEVELS)) u_chk (
    .in_vec  (in_vec),
    .idx_out (idx_out)
);

// File: tb/ohf_encoder_tb.sv
module ohf_encoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] stim = '0;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    bit          done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    logic [5:0] idx6;
    logic [4:0] idx5;
    logic [3:0] idx4;
    logic [2:0] idx3;
    logic [1:0] idx2;
    logic [0:0] idx1;

    ohf_encoder #(.LEVELS(6)) u_dut (.in_vec(stim[63:0]), .idx_out(idx6));
    ohf_encoder #(.LEVELS(5)) u_n5  (.in_vec(stim[31:0]), .idx_out(idx5));
    ohf_encoder #(.LEVELS(4)) u_n4  (.in_vec(stim[15:0]), .idx_out(idx4));
    ohf_encoder #(.LEVELS(3)) u_n3  (.in_vec(stim[7:0]),  .idx_out(idx3));
    ohf_encoder #(.LEVELS(2)) u_n2  (.in_vec(stim[3:0]),  .idx_out(idx2));
    ohf_encoder #(.LEVELS(1)) u_n1  (.in_vec(stim[1:0]),  .idx_out(idx1));

    // Expected index for a word of 2^levels bits taken from the stimulus.
    function automatic int expect_idx(input logic [63:0] s, input int levels);
        logic [63:0] m;
        m = (levels >= 6) ? s : (s & ((64'd1 << (1 << levels)) - 64'd1));
        for (int i = 0; i < 64; i++) begin
            if (m[i]) return i;
        end
        return 0;
    endfunction

    function automatic int actual_idx(input int levels);
        case (levels)
            1: return int'(idx1);
            2: return int'(idx2);
            3: return int'(idx3);
            4: return int'(idx4);
            5: return int'(idx5);
            default: return int'(idx6);
        endcase
    endfunction

    task automatic check(input int act, input int exp, input string req);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (stim %h)", req, act, exp, stim);
        end
    endtask

    // Apply a stimulus on a rising edge, sample on the following falling edge.
    task automatic apply(input logic [63:0] s);
        @(posedge clk);
        stim = s;
        @(negedge clk);
    endtask

    task automatic check_all(input string req);
        for (int lv = 1; lv <= 6; lv++) begin
            check(actual_idx(lv), expect_idx(stim, lv), req);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));

        // Reset state: zero input, every size reports zero (R2).
        @(negedge clk);
        for (int lv = 1; lv <= 6; lv++) check(actual_idx(lv), 0, "R2 reset");
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // Walk one set bit through every position (R1; smaller sizes see zero: R2).
        for (int j = 0; j < 64; j++) begin
            apply(64'd1 << j);
            check_all(j < 2 ? "R1" : "R1/R2");
            // R4: MSB marks the upper half of the 64-bit word.
            check(int'(idx6[5]), (j >= 32) ? 1 : 0, "R4");
            // R5: low bits give the position within the half.
            check(int'(idx6[4:0]), j % 32, "R5");
        end

        // Explicit all-zero input (R2).
        apply('0);
        check_all("R2");

        // Base case (R3).
        apply(64'h2);
        check(int'(idx1), 1, "R3");
        apply(64'h1);
        check(int'(idx1), 0, "R3");

        // Worked example (R6).
        apply(64'h20);
        check(int'(idx3), 5, "R6");

        // Random single-bit patterns (R1, R4, R5).
        for (int k = 0; k < 200; k++) begin
            int pos;
            pos = int'($urandom_range(63, 0));
            apply(64'd1 << pos);
            check_all("R1");
            check(int'(idx6[5]), (pos >= 32) ? 1 : 0, "R4");
            check(int'(idx6[4:0]), pos % 32, "R5");
        end

        apply('0);
        check_all("R2");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule